// File: doc/BRIEF.md
# Programmable Edge Prescaler with Pulse Output

The block counts rising transitions on a slow, asynchronous event line and emits one output pulse of fixed length for every N transitions it counts. N comes from an 8-bit divide-ratio bus and may change while the block is running. The event line is never used as a clock. A synchronizer brings it into the system clock domain, and an edge detector turns each low-to-high transition into a strobe that lasts one clock cycle.

A modulo-N counter advances on each strobe. On its terminal count it tells a pulse timer to start. The timer holds the output high for a set number of system clock cycles. The default of 50 cycles gives 1 µs at 50 MHz. The event line is assumed to be clean already, so the block has no debounce logic.

Top module: `pulse_prescaler`

## Requirements
- R1: While reset (`rstN` low) is asserted, `pulseOut` is 0 and the edge counter is cleared. After reset, the first pulse needs a full N new edges, and a pulse in progress is cut off by reset.
- R2: For a constant ratio N in the range 2 to 255, the number of output pulses equals floor(E/N), where E is the number of event rising edges.
- R3: Each output pulse that no new terminal count interrupts is high for exactly PULSE_CYCLES consecutive clock cycles (default 50) and then returns low.
- R4: A ratio of 0 or of 1 makes every detected rising edge produce a pulse.
- R5: Only low-to-high transitions count. An event input held high for many cycles counts as a single edge.
- R6: A terminal count that arrives while a pulse is active restarts the pulse timer. The output stays high without a gap until PULSE_CYCLES cycles after the last terminal count.
- R7: The ratio is read at each detected edge. If it is lowered to a value at or below the current count plus one, the next edge fires a pulse and clears the count.
- R8: Each input rising edge produces a detect strobe that is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventIn | input | 1 | Asynchronous event line, already debounced |
| divRatio | input | 8 | Divide ratio N (0 and 1 both mean divide by one) |
| pulseOut | output | 1 | Output pulse, PULSE_CYCLES clocks wide |

## Verification
If the edge counter holds a wrong value, the pulse count comes out wrong within one ratio period of input edges. For example, a counter that is not cleared by reset fires one edge early after reset. If the pulse timer is loaded or decremented wrongly, the measured width differs from 50 on the very first pulse. A timer that ignores a retrigger shows a gap or a short merged pulse within one pulse length. An edge detector that fires on level shows up at once as extra pulses while the input is held high.

// File: rtl/pulse_prescaler_pkg.sv
package pulse_prescaler_pkg;
  // Strobes passed from the counting control to the pulse datapath
  typedef struct packed {
    logic edgeSeen;   // one-cycle strobe per synchronized rising edge
    logic terminal;   // one-cycle strobe when the count wraps
  } strobe_t;
endpackage

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
  import pulse_prescaler_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               eventIn,
  input  logic [RATIO_W-1:0] divRatio,
  output strobe_t            stb
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevSample;
  logic                   edgeStb;
  logic                   fireQ;
  logic [RATIO_W-1:0]     edgeCnt;
  logic                   lastCount;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= eventIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  // registered rising-edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= 1'b0;
      edgeStb    <= 1'b0;
    end else begin
      prevSample <= syncQ[SYNC_STAGES-1];
      edgeStb    <= syncQ[SYNC_STAGES-1] & ~prevSample;
    end
  end

  assign lastCount = (divRatio <= ONE) || (edgeCnt >= divRatio - ONE);

  // modulo-N counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      fireQ   <= 1'b0;
    end else begin
      fireQ <= 1'b0;
      if (edgeStb) begin
        if (lastCount) begin
          edgeCnt <= '0;
          fireQ   <= 1'b1;
        end else begin
          edgeCnt <= edgeCnt + ONE;
        end
      end
    end
  end

  assign stb.edgeSeen = edgeStb;
  assign stb.terminal = fireQ;

  // R8
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeStb |=> !edgeStb);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !edgeStb |=> $stable(edgeCnt));

  // R5
  level_no_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevSample && syncQ[SYNC_STAGES-1]) |=> !edgeStb);
endmodule

// File: rtl/prescale_pulse.sv
module prescale_pulse
  import pulse_prescaler_pkg::*;
#(
  parameter int PULSE_CYCLES = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    pulseOut
);
  localparam int TW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES + 1);
  localparam logic [TW-1:0] RELOAD = TW'(PULSE_CYCLES - 1);

  logic [TW-1:0] remaining;
  logic          pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      pulseQ    <= 1'b0;
    end else if (stb.terminal) begin
      remaining <= RELOAD;
      pulseQ    <= 1'b1;
    end else if (remaining != '0) begin
      remaining <= remaining - TW'(1);
    end else begin
      pulseQ <= 1'b0;
    end
  end

  assign pulseOut = pulseQ;

  // R2
  terminal_from_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.terminal |-> $past(stb.edgeSeen));

  // R6
  pulse_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.terminal |=> (pulseQ && remaining == RELOAD));

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseQ && !stb.terminal) |=> !pulseQ);

  // R3
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remaining <= RELOAD);
endmodule

// File: rtl/pulse_prescaler.sv
module pulse_prescaler
  import pulse_prescaler_pkg::*;
#(
  parameter int RATIO_W      = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 50
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               eventIn,
  input  logic [RATIO_W-1:0] divRatio,
  output logic               pulseOut
);
  strobe_t stb;

  prescale_ctrl #(.RATIO_W(RATIO_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .divRatio(divRatio), .stb(stb)
  );

  prescale_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) i_pulse (
    .clk(clk), .rstN(rstN), .stb(stb), .pulseOut(pulseOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) !rstN |-> !pulseOut);
endmodule

// File: tb/test_pulse_prescaler.sv
module test_pulse_prescaler;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       eventIn = 1'b0;
  logic [7:0] divRatio = 8'd1;
  logic       pulseOut;

  int checks = 0, failures = 0;
  int pulseCount = 0, curWidth = 0, widthBad = 0, lastWidth = 0;
  int expWidth = 50;
  int cycles = 0;
  bit done = 0;

  pulse_prescaler i_pulse_prescaler (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .divRatio(divRatio), .pulseOut(pulseOut)
  );

  always #4 clk = ~clk;

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstN) curWidth = 0;
    else if (pulseOut) curWidth++;
    else if (curWidth > 0) begin
      pulseCount++;
      lastWidth = curWidth;
      if (curWidth != expWidth) widthBad++;
      curWidth = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic sendEdges(input int n, input int hiCyc, input int loCyc);
    for (int k = 0; k < n; k++) begin
      eventIn = 1'b1; waitCycles(hiCyc);
      eventIn = 1'b0; waitCycles(loCyc);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0; waitCycles(3);
    rstN = 1'b1; waitCycles(2);
    pulseCount = 0; widthBad = 0; expWidth = 50;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(pulseOut == 1'b0, "R1 output low in reset", pulseOut, 0);
    applyReset();
    @(negedge clk);
    check(pulseOut == 1'b0, "R1 output low after reset", pulseOut, 0);
    divRatio = 8'd3;
    sendEdges(2, 10, 60);
    applyReset();
    sendEdges(2, 10, 60); waitCycles(80);
    check(pulseCount == 0, "R1 counter cleared by reset", pulseCount, 0);
    sendEdges(1, 10, 60); waitCycles(80);
    check(pulseCount == 1, "R1 full N edges after reset", pulseCount, 1);
    divRatio = 8'd1;
    sendEdges(1, 10, 20);
    @(negedge clk);
    check(pulseOut == 1'b1, "R3 pulse active mid-pulse", pulseOut, 1);
    rstN = 1'b0;
    @(negedge clk);
    check(pulseOut == 1'b0, "R1 reset cuts pulse", pulseOut, 0);
    applyReset();
  endtask

  task automatic testDivide(input int ratio, input int edges);
    applyReset();
    divRatio = 8'(ratio);
    sendEdges(edges, 10, 65); waitCycles(80);
    check(pulseCount == edges / ratio, $sformatf("R2 pulses for N=%0d", ratio),
          pulseCount, edges / ratio);
    check(widthBad == 0, "R3 pulse width", lastWidth, 50);
  endtask

  task automatic testSmallRatio(input int ratio);
    applyReset();
    divRatio = 8'(ratio);
    sendEdges(5, 10, 65); waitCycles(80);
    check(pulseCount == 5, $sformatf("R4 every edge for N=%0d", ratio), pulseCount, 5);
    check(widthBad == 0, "R3 pulse width small ratio", lastWidth, 50);
  endtask

  task automatic testLevelHold();
    applyReset();
    divRatio = 8'd1;
    sendEdges(1, 300, 80);
    check(pulseCount == 1, "R5 held level counts once", pulseCount, 1);
    check(lastWidth == 50, "R8 single strobe gives one width", lastWidth, 50);
  endtask

  task automatic testRetrigger();
    applyReset();
    divRatio = 8'd1;
    expWidth = 90;
    sendEdges(3, 5, 15); waitCycles(100);
    check(pulseCount == 1, "R6 merged pulse count", pulseCount, 1);
    check(lastWidth == 90, "R6 merged pulse width", lastWidth, 90);
  endtask

  task automatic testRatioChange();
    applyReset();
    divRatio = 8'd5;
    sendEdges(3, 10, 65); waitCycles(80);
    check(pulseCount == 0, "R7 no pulse before change", pulseCount, 0);
    divRatio = 8'd2;
    sendEdges(1, 10, 65); waitCycles(80);
    check(pulseCount == 1, "R7 lowered ratio fires next edge", pulseCount, 1);
    sendEdges(2, 10, 65); waitCycles(80);
    check(pulseCount == 2, "R7 new ratio after wrap", pulseCount, 2);
  endtask

  initial begin
    testReset();
    testDivide(4, 12);
    testDivide(3, 7);
    testDivide(255, 255);
    testSmallRatio(1);
    testSmallRatio(0);
    testLevelHold();
    testRetrigger();
    testRatioChange();
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule